// File: doc/BRIEF.md
# Command/Data Stream Sequencer

This block consumes a stream of 17-bit words from an input FIFO. A flag bit sets each word apart as either a command or data. A command word picks an operation from its low byte. That operation then stays armed and handles every data word that follows, however many there are, until a new command replaces it. As a result, one opcode can drive a long burst without being sent again.

The operations set or sample eight I/O pins and update their direction. They pass 16-bit payloads with one-cycle strobes to a serial peripheral and to a PWM unit, and they select the channel of a 4-bit analog mux with a conversion request. A delay holds off the stream for a given number of cycles. A sixteen-entry register file can be written or read through an auto-incrementing pointer, and readback words leave through a one-deep valid/ready output stage. A halt command freezes intake until a resume input is asserted.

Top module: `cds_sequencer`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `pin_out`, `pin_dir`, `adc_sel` are 0 and no strobe is high.
- R2: A word with `in_is_cmd`=1 selects the operation from `in_payload[7:0]`. That operation stays active for any number of data words (`in_is_cmd`=0) that follow.
- R3: Under opcode 0x00 each data word drives `pin_out` from `in_payload[7:0]`, and `pin_out_we` pulses in the cycle after acceptance. Under 0x02 the same applies to `pin_dir` and `pin_dir_we`. `pin_out` changes only together with its strobe.
- R4: Under opcode 0x01 each data word places `{8'h00, pin_in}` in the output stage.
- R5: Under 0x03 or 0x04 a data word sets `per_data` and pulses `per_wr` or `per_rd`. Under 0x06 or 0x07 it sets `pwm_value` and pulses `pwm_on_we` or `pwm_off_we`. At most one strobe is high in any cycle.
- R6: Under opcode 0x05 a data word of value N holds `in_ready` low for exactly N cycles after acceptance.
- R7: Opcode 0x0B loads the pointer from `in_payload[3:0]`. Under 0x0C each data word is stored at the pointer, and the pointer then advances, wrapping from 15 to 0.
- R8: Under 0x0D a data word gives a count in `in_payload[4:0]`. The block then emits that many register words starting at the pointer, with the pointer advancing after each, and `in_ready` stays low until the last word is loaded.
- R9: Under opcode 0x08 each data word sets `adc_sel` from `in_payload[3:0]` and pulses `adc_req`. `adc_sel` changes only together with that strobe.
- R10: Opcodes 0x09 and 0x0A pulse `la_start` and `la_stop` respectively, one cycle after the command is accepted.
- R11: Data words that arrive before any command, after an undefined opcode (0x0E or above 0x0F) or after 0x09/0x0A are accepted and have no effect.
- R12: Opcode 0x0F drops `in_ready` until `resume` is sampled high. No operation is active afterwards.
- R13: A word in the output stage holds `out_data` while `out_ready` is low, and `in_ready` stays low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_is_cmd | input | 1 | 1 = command word, 0 = data word |
| in_payload | input | 16 | Word payload |
| resume | input | 1 | Leaves the halted state |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Driven pin levels |
| pin_out_we | output | 1 | Pin level update strobe |
| pin_dir | output | 8 | Pin direction bits |
| pin_dir_we | output | 1 | Direction update strobe |
| per_data | output | 16 | Word toward the serial peripheral |
| per_wr | output | 1 | Peripheral write strobe |
| per_rd | output | 1 | Peripheral read strobe |
| pwm_value | output | 16 | Period value toward the PWM unit |
| pwm_on_we | output | 1 | On-period load strobe |
| pwm_off_we | output | 1 | Off-period load strobe |
| adc_sel | output | 4 | Analog mux select |
| adc_req | output | 1 | Conversion request strobe |
| la_start | output | 1 | Capture start strobe |
| la_stop | output | 1 | Capture stop strobe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word taken when high with `out_valid` |
| out_data | output | 16 | Output word |

## Verification
The pin-write opcode is driven with several data words after a single command. This separates an operation that stays armed from one that consumes just one word. Register writes start near the top of the file so that they cross the wrap, and readback starts below that point. Two counts are issued under one read command, which exposes wrong pointer advance, a wrong start address and loss of the armed opcode. Delays of 20 and 0, a stalled output consumer, stray data before any command, an undefined opcode and a halt each show whether intake stops or resumes in exactly the right cycles, and whether ignored words leave the outputs untouched.

// File: rtl/cds_pkg.sv
package cds_pkg;

    typedef enum logic [7:0] {
        OP_PIN_SET   = 8'h00,
        OP_PIN_GET   = 8'h01,
        OP_PIN_DIR   = 8'h02,
        OP_PER_WR    = 8'h03,
        OP_PER_RD    = 8'h04,
        OP_WAIT      = 8'h05,
        OP_PWM_HI    = 8'h06,
        OP_PWM_LO    = 8'h07,
        OP_ADC       = 8'h08,
        OP_CAP_GO    = 8'h09,
        OP_CAP_END   = 8'h0A,
        OP_PTR       = 8'h0B,
        OP_REG_WR    = 8'h0C,
        OP_REG_RD    = 8'h0D,
        OP_HALT      = 8'h0F
    } op_e;

    // Opcodes that arm a data-consuming operation.
    function automatic logic op_takes_data(input logic [7:0] code);
        return (code <= 8'h08) || (code >= 8'h0B && code <= 8'h0D);
    endfunction

endpackage

// File: rtl/cds_delay.sv
module cds_delay #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/cds_regfile.sv
module cds_regfile #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_adv,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr
);
    logic [PTR_W-1:0]  ptr_d, ptr_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (ptr_load) begin
            ptr_d = ptr_val;
        end else if (wr_en || rd_adv) begin
            ptr_d = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [DATA_W-1:0] ent_d;
        always_comb begin
            ent_d = mem_q[g];
            if (wr_en && ptr_q == PTR_W'(g)) ent_d = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= ent_d;
        end
    end

    assign rd_data = mem_q[ptr_q];
    assign ptr     = ptr_q;
endmodule

// File: rtl/cds_sequencer.sv
module cds_sequencer
    import cds_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PIN_W  = 8,
    parameter int SEL_W  = 4,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_is_cmd,
    input  logic [DATA_W-1:0] in_payload,
    input  logic              resume,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic              pin_out_we,
    output logic [PIN_W-1:0]  pin_dir,
    output logic              pin_dir_we,
    output logic [DATA_W-1:0] per_data,
    output logic              per_wr,
    output logic              per_rd,
    output logic [DATA_W-1:0] pwm_value,
    output logic              pwm_on_we,
    output logic              pwm_off_we,
    output logic [SEL_W-1:0]  adc_sel,
    output logic              adc_req,
    output logic              la_start,
    output logic              la_stop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        op_e               op;
        logic              armed;
        logic              halted;
        logic [PIN_W-1:0]  pin_out;
        logic              pin_out_we;
        logic [PIN_W-1:0]  pin_dir;
        logic              pin_dir_we;
        logic [DATA_W-1:0] per_data;
        logic              per_wr;
        logic              per_rd;
        logic [DATA_W-1:0] pwm_value;
        logic              pwm_on_we;
        logic              pwm_off_we;
        logic [SEL_W-1:0]  adc_sel;
        logic              adc_req;
        logic              la_start;
        logic              la_stop;
        logic [CNT_W-1:0]  rd_left;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
    } seq_t;

    seq_t s_d, s_q;

    logic              dly_busy;
    logic              dly_load;
    logic              rf_ptr_load;
    logic              rf_wr;
    logic              rf_adv;
    logic [DATA_W-1:0] rf_rd_data;
    logic [PTR_W-1:0]  rf_ptr;
    logic              out_free;
    logic              take;
    logic              take_cmd;
    logic              take_dat;
    logic              halt_w;
    logic              rd_pend;

    assign out_free = !s_q.out_valid || out_ready;
    assign halt_w   = s_q.halted;
    assign rd_pend  = (s_q.rd_left != '0);
    assign in_ready = !s_q.halted && !dly_busy && !rd_pend && out_free;
    assign take     = in_valid && in_ready;
    assign take_cmd = take && in_is_cmd;
    assign take_dat = take && !in_is_cmd && s_q.armed;

    always_comb begin
        s_d            = s_q;
        s_d.pin_out_we = 1'b0;
        s_d.pin_dir_we = 1'b0;
        s_d.per_wr     = 1'b0;
        s_d.per_rd     = 1'b0;
        s_d.pwm_on_we  = 1'b0;
        s_d.pwm_off_we = 1'b0;
        s_d.adc_req    = 1'b0;
        s_d.la_start   = 1'b0;
        s_d.la_stop    = 1'b0;
        dly_load       = 1'b0;
        rf_ptr_load    = 1'b0;
        rf_wr          = 1'b0;
        rf_adv         = 1'b0;

        if (s_q.out_valid && out_ready) s_d.out_valid = 1'b0;
        if (s_q.halted && resume)       s_d.halted    = 1'b0;

        if (take_cmd) begin
            s_d.op    = op_e'(in_payload[7:0]);
            s_d.armed = op_takes_data(in_payload[7:0]);
            case (in_payload[7:0])
                OP_HALT:    s_d.halted   = 1'b1;
                OP_CAP_GO:  s_d.la_start = 1'b1;
                OP_CAP_END: s_d.la_stop  = 1'b1;
                default: ;
            endcase
        end

        if (take_dat) begin
            case (s_q.op)
                OP_PIN_SET: begin
                    s_d.pin_out    = in_payload[PIN_W-1:0];
                    s_d.pin_out_we = 1'b1;
                end
                OP_PIN_DIR: begin
                    s_d.pin_dir    = in_payload[PIN_W-1:0];
                    s_d.pin_dir_we = 1'b1;
                end
                OP_PIN_GET: begin
                    s_d.out_valid = 1'b1;
                    s_d.out_data  = {{(DATA_W-PIN_W){1'b0}}, pin_in};
                end
                OP_PER_WR: begin
                    s_d.per_data = in_payload;
                    s_d.per_wr   = 1'b1;
                end
                OP_PER_RD: begin
                    s_d.per_data = in_payload;
                    s_d.per_rd   = 1'b1;
                end
                OP_PWM_HI: begin
                    s_d.pwm_value = in_payload;
                    s_d.pwm_on_we = 1'b1;
                end
                OP_PWM_LO: begin
                    s_d.pwm_value  = in_payload;
                    s_d.pwm_off_we = 1'b1;
                end
                OP_ADC: begin
                    s_d.adc_sel = in_payload[SEL_W-1:0];
                    s_d.adc_req = 1'b1;
                end
                OP_WAIT:   dly_load    = 1'b1;
                OP_PTR:    rf_ptr_load = 1'b1;
                OP_REG_WR: rf_wr       = 1'b1;
                OP_REG_RD: s_d.rd_left = in_payload[CNT_W-1:0];
                default: ;
            endcase
        end

        if (rd_pend && out_free) begin
            s_d.out_valid = 1'b1;
            s_d.out_data  = rf_rd_data;
            s_d.rd_left   = s_q.rd_left - 1'b1;
            rf_adv        = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.op <= OP_PIN_SET;
        end else begin
            s_q <= s_d;
        end
    end

    cds_delay #(.CNT_W(DATA_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (in_payload),
        .busy     (dly_busy)
    );

    cds_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_load (rf_ptr_load),
        .ptr_val  (in_payload[PTR_W-1:0]),
        .wr_en    (rf_wr),
        .wr_data  (in_payload),
        .rd_adv   (rf_adv),
        .rd_data  (rf_rd_data),
        .ptr      (rf_ptr)
    );

    assign pin_out    = s_q.pin_out;
    assign pin_out_we = s_q.pin_out_we;
    assign pin_dir    = s_q.pin_dir;
    assign pin_dir_we = s_q.pin_dir_we;
    assign per_data   = s_q.per_data;
    assign per_wr     = s_q.per_wr;
    assign per_rd     = s_q.per_rd;
    assign pwm_value  = s_q.pwm_value;
    assign pwm_on_we  = s_q.pwm_on_we;
    assign pwm_off_we = s_q.pwm_off_we;
    assign adc_sel    = s_q.adc_sel;
    assign adc_req    = s_q.adc_req;
    assign la_start   = s_q.la_start;
    assign la_stop    = s_q.la_stop;
    assign out_valid  = s_q.out_valid;
    assign out_data   = s_q.out_data;

    logic unused_ptr;
    assign unused_ptr = ^rf_ptr;
endmodule

// File: rtl/cds_sequencer_chk.sv
module cds_sequencer_chk #(
    parameter int DATA_W = 16,
    parameter int PIN_W  = 8,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              halt_st,
    input logic              dly_busy,
    input logic              rd_pend,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [PIN_W-1:0]  pin_out,
    input logic              pin_out_we,
    input logic [SEL_W-1:0]  adc_sel,
    input logic              adc_req,
    input logic [6:0]        strobes
);
    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_st |-> !in_ready);                                   // R12
    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        dly_busy |-> !in_ready);                                  // R6
    AST_READBACK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |-> !in_ready);                                   // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R13
    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_out_we |-> $stable(pin_out));                        // R3
    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_req |-> $stable(adc_sel));                           // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));                                       // R5
endmodule

bind cds_sequencer cds_sequencer_chk #(
    .DATA_W(DATA_W), .PIN_W(PIN_W), .SEL_W(SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .halt_st    (halt_w),
    .dly_busy   (dly_busy),
    .rd_pend    (rd_pend),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .pin_out    (pin_out),
    .pin_out_we (pin_out_we),
    .adc_sel    (adc_sel),
    .adc_req    (adc_req),
    .strobes    ({pin_out_we, pin_dir_we, per_wr, per_rd, pwm_on_we, pwm_off_we, adc_req})
);

// File: tb/sim_cds_sequencer.sv
module sim_cds_sequencer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_is_cmd = 1'b0;
    logic [15:0] in_payload = '0;
    logic        resume = 1'b0;
    logic [7:0]  pin_in = '0;
    logic        out_ready = 1'b1;
    logic        in_ready;
    logic [7:0]  pin_out, pin_dir;
    logic        pin_out_we, pin_dir_we;
    logic [15:0] per_data, pwm_value, out_data;
    logic        per_wr, per_rd, pwm_on_we, pwm_off_we;
    logic [3:0]  adc_sel;
    logic        adc_req, la_start, la_stop, out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int n_pin_we = 0, n_dir_we = 0, n_per_wr = 0, n_per_rd = 0;
    int n_pwm_on = 0, n_pwm_off = 0, n_adc = 0, n_la_go = 0, n_la_end = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cds_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_cmd(in_is_cmd), .in_payload(in_payload), .resume(resume),
        .pin_in(pin_in), .pin_out(pin_out), .pin_out_we(pin_out_we),
        .pin_dir(pin_dir), .pin_dir_we(pin_dir_we), .per_data(per_data),
        .per_wr(per_wr), .per_rd(per_rd), .pwm_value(pwm_value),
        .pwm_on_we(pwm_on_we), .pwm_off_we(pwm_off_we), .adc_sel(adc_sel),
        .adc_req(adc_req), .la_start(la_start), .la_stop(la_stop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // strobe counters, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_pin_we  <= n_pin_we  + int'(pin_out_we);
            n_dir_we  <= n_dir_we  + int'(pin_dir_we);
            n_per_wr  <= n_per_wr  + int'(per_wr);
            n_per_rd  <= n_per_rd  + int'(per_rd);
            n_pwm_on  <= n_pwm_on  + int'(pwm_on_we);
            n_pwm_off <= n_pwm_off + int'(pwm_off_we);
            n_adc     <= n_adc     + int'(adc_req);
            n_la_go   <= n_la_go   + int'(la_start);
            n_la_end  <= n_la_end  + int'(la_stop);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive one word; returns at the falling edge after it was accepted
    task automatic send(input bit cmd, input logic [15:0] val);
        @(negedge clk);
        in_valid = 1'b1; in_is_cmd = cmd; in_payload = val;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_is_cmd = 1'b0;
    endtask

    task automatic get_out(output logic [15:0] v);
        #1;
        while (!out_valid) begin
            @(negedge clk);
            #1;
        end
        v = out_data;
        @(negedge clk);
    endtask

    task automatic t_reset;
        #1;
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 pin_out/pin_dir/adc_sel", int'({pin_out, pin_dir, adc_sel}), 0);
        check("R1 strobes", int'({pin_out_we, pin_dir_we, per_wr, per_rd, pwm_on_we,
                                  pwm_off_we, adc_req, la_start, la_stop}), 0);
    endtask

    task automatic t_discard_first;
        send(1'b0, 16'h00AB);
        repeat (2) @(negedge clk);
        #1;
        check("R11 data before command pin_out", int'(pin_out), 0);
        check("R11 data before command out_valid", int'(out_valid), 0);
        check("R11 data before command strobes", n_pin_we + n_adc + n_per_wr, 0);
    endtask

    task automatic t_pin_stream;
        send(1'b1, 16'h0000);
        send(1'b0, 16'hFF11);
        #1 check("R3 pin_out first", int'(pin_out), 8'h11);
        check("R3 pin_out_we pulse", int'(pin_out_we), 1);
        send(1'b0, 16'h0022);
        send(1'b0, 16'h0033);
        send(1'b0, 16'h00C4);
        #1 check("R2 opcode persists across data words", int'(pin_out), 8'hC4);
        @(negedge clk);
        check("R2 one strobe per data word", n_pin_we, 4);
        send(1'b1, 16'h0002);
        send(1'b0, 16'h005A);
        #1 check("R3 pin_dir", int'(pin_dir), 8'h5A);
        check("R3 pin_dir_we", int'(pin_dir_we), 1);
        check("R3 pin_out untouched by direction", int'(pin_out), 8'hC4);
    endtask

    task automatic t_pin_read;
        logic [15:0] v;
        send(1'b1, 16'h0001);
        pin_in = 8'h5A;
        send(1'b0, 16'h0000);
        get_out(v);
        check("R4 pin read word 1", int'(v), 16'h005A);
        pin_in = 8'hC3;
        send(1'b0, 16'h0000);
        get_out(v);
        check("R4 pin read word 2", int'(v), 16'h00C3);
    endtask

    task automatic t_periph_pwm;
        send(1'b1, 16'h0003);
        send(1'b0, 16'hBEEF);
        #1 check("R5 per_data write", int'(per_data), 16'hBEEF);
        check("R5 per_wr", int'(per_wr), 1);
        send(1'b1, 16'h0004);
        send(1'b0, 16'h1234);
        #1 check("R5 per_data read", int'(per_data), 16'h1234);
        check("R5 per_rd", int'(per_rd), 1);
        send(1'b1, 16'h0006);
        send(1'b0, 16'h0100);
        #1 check("R5 pwm on value", int'(pwm_value), 16'h0100);
        check("R5 pwm_on_we", int'(pwm_on_we), 1);
        send(1'b1, 16'h0007);
        send(1'b0, 16'h0200);
        #1 check("R5 pwm off value", int'(pwm_value), 16'h0200);
        check("R5 pwm_off_we", int'(pwm_off_we), 1);
    endtask

    task automatic t_delay;
        int low;
        send(1'b1, 16'h0005);
        send(1'b0, 16'd20);
        low = 0;
        #1;
        while (!in_ready && low < 1000) begin
            low++;
            @(negedge clk);
            #1;
        end
        check("R6 stall cycles for 20", low, 20);
        send(1'b0, 16'd0);
        #1 check("R6 zero delay no stall", int'(in_ready), 1);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        send(1'b1, 16'h000B);
        send(1'b0, 16'h0000);
        send(1'b1, 16'h000C);
        for (int i = 0; i < 16; i++) send(1'b0, 16'h1000 + 16'(i) * 16'h0111);
        send(1'b1, 16'h000B);
        send(1'b0, 16'h000E);
        send(1'b1, 16'h000C);
        send(1'b0, 16'hA1A1);
        send(1'b0, 16'hB2B2);
        send(1'b0, 16'hC3C3);
        send(1'b1, 16'h000B);
        send(1'b0, 16'h000D);
        send(1'b1, 16'h000D);
        send(1'b0, 16'h0004);
        #1 check("R8 in_ready low during readback", int'(in_ready), 0);
        get_out(v); check("R8 readback reg13", int'(v), 16'h1DDD);
        get_out(v); check("R7 readback reg14", int'(v), 16'hA1A1);
        get_out(v); check("R7 readback reg15", int'(v), 16'hB2B2);
        get_out(v); check("R7 wrap to reg0", int'(v), 16'hC3C3);
        send(1'b0, 16'h0002);
        get_out(v); check("R8 pointer advanced reg1", int'(v), 16'h1111);
        get_out(v); check("R8 pointer advanced reg2", int'(v), 16'h1222);
        repeat (2) @(negedge clk);
        #1 check("R8 no extra words", int'(out_valid), 0);
    endtask

    task automatic t_adc_la;
        int a0, g0, e0;
        a0 = n_adc;
        send(1'b1, 16'h0008);
        send(1'b0, 16'hFF35);
        #1 check("R9 adc_sel", int'(adc_sel), 5);
        send(1'b0, 16'h000C);
        #1 check("R9 adc_sel second", int'(adc_sel), 12);
        @(negedge clk);
        check("R9 one request per word", n_adc - a0, 2);
        g0 = n_la_go; e0 = n_la_end;
        send(1'b1, 16'h0009);
        #1 check("R10 la_start pulse", int'(la_start), 1);
        send(1'b0, 16'h00FF);
        send(1'b1, 16'h000A);
        #1 check("R10 la_stop pulse", int'(la_stop), 1);
        @(negedge clk);
        check("R10 counts", (n_la_go - g0) * 16 + (n_la_end - e0), 17);
        check("R11 data after capture start ignored", int'(adc_sel), 12);
    endtask

    task automatic t_unknown;
        int p0;
        p0 = n_pin_we;
        send(1'b1, 16'h000E);
        send(1'b0, 16'h0099);
        send(1'b1, 16'h0042);
        send(1'b0, 16'h0077);
        repeat (2) @(negedge clk);
        #1 check("R11 unknown opcode pin_out", int'(pin_out), 8'hC4);
        check("R11 unknown opcode no output", int'(out_valid), 0);
        check("R11 unknown opcode no strobe", n_pin_we - p0, 0);
    endtask

    task automatic t_halt;
        int p0;
        send(1'b1, 16'h0000);
        send(1'b1, 16'h000F);
        repeat (3) @(negedge clk);
        #1 check("R12 halted in_ready", int'(in_ready), 0);
        @(negedge clk);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        #1 check("R12 resumed in_ready", int'(in_ready), 1);
        p0 = n_pin_we;
        send(1'b0, 16'h0066);
        repeat (2) @(negedge clk);
        #1 check("R12 no op armed after halt", int'(pin_out), 8'hC4);
        check("R12 no strobe after halt", n_pin_we - p0, 0);
    endtask

    task automatic t_backpressure;
        out_ready = 1'b0;
        send(1'b1, 16'h0001);
        pin_in = 8'h3C;
        send(1'b0, 16'h0000);
        #1 check("R13 word presented", int'(out_data), 16'h003C);
        check("R13 in_ready low while full", int'(in_ready), 0);
        pin_in = 8'h77;
        repeat (3) @(negedge clk);
        #1 check("R13 data held", int'(out_data), 16'h003C);
        check("R13 valid held", int'(out_valid), 1);
        check("R13 still blocked", int'(in_ready), 0);
        @(negedge clk);
        out_ready = 1'b1;
        #1 check("R13 in_ready with consumer ready", int'(in_ready), 1);
        @(negedge clk);
        #1 check("R13 word taken", int'(out_valid), 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_discard_first();
        t_pin_stream();
        t_pin_read();
        t_periph_pwm();
        t_delay();
        t_regs();
        t_adc_la();
        t_unknown();
        t_halt();
        t_backpressure();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule